// File: doc/BRIEF.md
# Way-Gated Set-Associative Translation Buffer

This block caches virtual-to-physical page translations in a small set-associative array whose ways can be switched off one by one at run time. A lookup request carries a virtual page number (VPN). One cycle later the block answers with hit or miss, the physical page number (PPN) and the recency rank of the entry that hit. That rank is the input for an external policy that estimates how many misses would follow if fewer ways were active.

A separate fill port installs translations, and only ever into enabled ways. Clearing a bit of the enable mask drops that way's entries in every set at the next clock edge. No writeback takes place, because the entries are clean copies. Each set keeps a full recency order of its ways. Setting the set count to one turns the array into a fully associative buffer in which each entry is its own way.

Top module: `way_gated_tlb`

## Requirements
- R1: After reset no entry is valid, `rsp_valid_o` is low, and every lookup misses until a fill has been made.
- R2: A lookup selects the set from the low log2(SETS) bits of the VPN. It hits when a valid, enabled way in that set holds the full VPN as its tag. The response appears with `rsp_valid_o` high on the cycle after the request, carrying the stored PPN.
- R3: A miss response has `rsp_hit_o`=0, `rsp_ppn_o`=0 and `rsp_pos_o`=0.
- R4: On a hit, `rsp_pos_o` is the number of valid entries in the set that were used more recently than the hit entry, so 0 means most recently used.
- R5: A lookup hit makes its entry the most recent in its set. Entries that were more recent than it each move back by one place.
- R6: A fill to a VPN not present in the set goes to the lowest-numbered invalid enabled way. When every enabled way is valid, it replaces the least recently used enabled way. The filled entry becomes the most recent.
- R7: A fill to a VPN already present in an enabled way rewrites that entry's PPN in place and makes it the most recent. No second copy is created.
- R8: While a way's enable bit is 0, that way takes no part in lookups in the same cycle, and all of its entries are invalid from the next edge onward. A way that is enabled again starts empty.
- R9: With the enable mask all zero, fills are dropped and every lookup misses.
- R10: When a lookup and a fill target the same set in one cycle, the lookup is answered from the contents held before the fill. Only the fill updates the recency order. When they target different sets, both take effect.
- R11: With SETS=1 the block acts as a fully associative buffer of WAYS entries with least-recently-used replacement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_vpn_i | input | VPN_W | VPN to translate |
| fill_valid_i | input | 1 | Fill request |
| fill_vpn_i | input | VPN_W | VPN to install |
| fill_ppn_i | input | PPN_W | PPN to install |
| way_en_i | input | WAYS | Per-way enable mask |
| rsp_valid_o | output | 1 | Response valid (one cycle after lookup) |
| rsp_hit_o | output | 1 | Lookup hit |
| rsp_ppn_o | output | PPN_W | Translated PPN, zero on miss |
| rsp_pos_o | output | log2(WAYS) | Recency rank of the hit entry |

## Verification
A lookup and a fill can arrive in the same cycle, and the hard case is when both select the same set. The lookup must then see the contents held before the fill, and its recency update must give way to the fill's. A dedicated phase forces the fill VPN into the lookup's set, often with the same VPN, while the enable mask changes underneath. Every response is judged against a behavioural model that keeps one recency queue per set and applies the fill before it discards the lookup's update.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned DEF_WAYS  = 8;
  localparam int unsigned DEF_SETS  = 16;
  localparam int unsigned DEF_VPN_W = 20;
  localparam int unsigned DEF_PPN_W = 20;

  // Which event moves an entry to the front of its set's recency order.
  typedef enum logic [1:0] {
    TOUCH_NONE = 2'd0,
    TOUCH_HIT  = 2'd1,
    TOUCH_FILL = 2'd2
  } touch_src_e;
endpackage

// File: rtl/tlb_way_match.sv
module tlb_way_match #(
  parameter int unsigned WAYS  = 8,
  parameter int unsigned VPN_W = 20,
  localparam int unsigned POS_W = $clog2(WAYS)
) (
  input  logic [WAYS*VPN_W-1:0] tags_i,
  input  logic [WAYS-1:0]       valid_i,
  input  logic [WAYS-1:0]       en_i,
  input  logic [VPN_W-1:0]      key_i,
  output logic                  hit_o,
  output logic [WAYS-1:0]       hit_vec_o,
  output logic [POS_W-1:0]      hit_way_o
);
  always_comb begin
    hit_way_o = '0;
    for (int w = 0; w < WAYS; w++) begin
      hit_vec_o[w] = valid_i[w] && en_i[w] && (tags_i[w*VPN_W +: VPN_W] == key_i);
      if (hit_vec_o[w]) hit_way_o = POS_W'(w);
    end
    hit_o = |hit_vec_o;
  end
endmodule

// File: rtl/tlb_victim_pick.sv
module tlb_victim_pick #(
  parameter int unsigned WAYS = 8,
  localparam int unsigned POS_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]       valid_i,
  input  logic [WAYS-1:0]       en_i,
  input  logic [WAYS*POS_W-1:0] rank_i,
  output logic                  found_o,
  output logic [POS_W-1:0]      way_o
);
  logic [WAYS-1:0]  free_vec;
  logic [POS_W-1:0] free_way;
  logic [POS_W-1:0] old_way;
  logic [POS_W-1:0] old_rank;
  logic             old_seen;

  always_comb begin
    free_vec = ~valid_i & en_i;
    free_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (free_vec[w]) free_way = POS_W'(w);
    end
    old_way  = '0;
    old_rank = '0;
    old_seen = 1'b0;
    for (int w = 0; w < WAYS; w++) begin
      if (en_i[w] && (!old_seen || rank_i[w*POS_W +: POS_W] > old_rank)) begin
        old_seen = 1'b1;
        old_rank = rank_i[w*POS_W +: POS_W];
        old_way  = POS_W'(w);
      end
    end
    found_o = |en_i;
    way_o   = (|free_vec) ? free_way : old_way;
  end
endmodule

// File: rtl/tlb_lru_stack.sv
module tlb_lru_stack #(
  parameter int unsigned WAYS = 8,
  localparam int unsigned POS_W = $clog2(WAYS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  touch_i,
  input  logic [POS_W-1:0]      touch_way_i,
  output logic [WAYS*POS_W-1:0] rank_o
);
  logic [POS_W-1:0] rank_q [WAYS];
  logic [POS_W-1:0] rank_d [WAYS];
  logic [POS_W-1:0] touched_rank;
  logic [WAYS-1:0]  seen;

  always_comb begin
    touched_rank = rank_q[touch_way_i];
    for (int w = 0; w < WAYS; w++) begin
      rank_d[w] = rank_q[w];
      if (touch_i) begin
        if (POS_W'(w) == touch_way_i)       rank_d[w] = '0;
        else if (rank_q[w] < touched_rank)  rank_d[w] = rank_q[w] + POS_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int w = 0; w < WAYS; w++) rank_q[w] <= POS_W'(w);
    end else if (touch_i) begin
      for (int w = 0; w < WAYS; w++) rank_q[w] <= rank_d[w];
    end
  end

  always_comb begin
    seen = '0;
    for (int w = 0; w < WAYS; w++) begin
      rank_o[w*POS_W +: POS_W] = rank_q[w];
      seen[rank_q[w]] = 1'b1;
    end
  end

  // R5
  lru_perm_chk: assert property (@(posedge clk) disable iff (!rst_n) &seen);

  // R5
  lru_front_chk: assert property (@(posedge clk) disable iff (!rst_n)
    touch_i |=> (rank_q[$past(touch_way_i)] == '0));
endmodule

// File: rtl/way_gated_tlb.sv
module way_gated_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned WAYS  = DEF_WAYS,
  parameter int unsigned SETS  = DEF_SETS,
  parameter int unsigned VPN_W = DEF_VPN_W,
  parameter int unsigned PPN_W = DEF_PPN_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid_i,
  input  logic [VPN_W-1:0]         lk_vpn_i,
  input  logic                     fill_valid_i,
  input  logic [VPN_W-1:0]         fill_vpn_i,
  input  logic [PPN_W-1:0]         fill_ppn_i,
  input  logic [WAYS-1:0]          way_en_i,
  output logic                     rsp_valid_o,
  output logic                     rsp_hit_o,
  output logic [PPN_W-1:0]         rsp_ppn_o,
  output logic [$clog2(WAYS)-1:0]  rsp_pos_o
);
  localparam int unsigned POS_W = $clog2(WAYS);
  localparam int unsigned IDX_W = (SETS > 1) ? $clog2(SETS) : 1;

  logic [VPN_W-1:0]      tag_q  [SETS][WAYS];
  logic [PPN_W-1:0]      ppn_q  [SETS][WAYS];
  logic [WAYS-1:0]       val_q  [SETS];
  logic [WAYS-1:0]       val_d  [SETS];
  logic [WAYS*POS_W-1:0] rank_all [SETS];

  logic [IDX_W-1:0]      lk_set, fl_set;
  logic [WAYS*VPN_W-1:0] lk_tags, fl_tags;
  logic                  lk_hit, fl_hit, vic_found;
  logic [WAYS-1:0]       lk_hit_vec, fl_hit_vec;
  logic [POS_W-1:0]      lk_way, fl_way, vic_way, fill_tgt;
  logic [WAYS*POS_W-1:0] lk_rank, fl_rank;
  logic                  lk_hit_act, fill_do;
  logic [POS_W-1:0]      hit_rank, pos_d;
  logic [PPN_W-1:0]      ppn_d;
  touch_src_e            touch_src [SETS];
  logic [SETS-1:0]       touch;
  logic [POS_W-1:0]      touch_way [SETS];
  logic [WAYS-1:0]       way_live;

  // Set selection: the low VPN bits, or a single set.
  if (SETS > 1) begin : g_idx
    assign lk_set = lk_vpn_i[IDX_W-1:0];
    assign fl_set = fill_vpn_i[IDX_W-1:0];
  end else begin : g_one_set
    assign lk_set = '0;
    assign fl_set = '0;
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_tags[w*VPN_W +: VPN_W] = tag_q[lk_set][w];
      fl_tags[w*VPN_W +: VPN_W] = tag_q[fl_set][w];
    end
    lk_rank = rank_all[lk_set];
    fl_rank = rank_all[fl_set];
  end

  tlb_way_match #(.WAYS(WAYS), .VPN_W(VPN_W)) u_lk_match (
    .tags_i(lk_tags), .valid_i(val_q[lk_set]), .en_i(way_en_i), .key_i(lk_vpn_i),
    .hit_o(lk_hit), .hit_vec_o(lk_hit_vec), .hit_way_o(lk_way)
  );

  tlb_way_match #(.WAYS(WAYS), .VPN_W(VPN_W)) u_fl_match (
    .tags_i(fl_tags), .valid_i(val_q[fl_set]), .en_i(way_en_i), .key_i(fill_vpn_i),
    .hit_o(fl_hit), .hit_vec_o(fl_hit_vec), .hit_way_o(fl_way)
  );

  tlb_victim_pick #(.WAYS(WAYS)) u_victim (
    .valid_i(val_q[fl_set]), .en_i(way_en_i), .rank_i(fl_rank),
    .found_o(vic_found), .way_o(vic_way)
  );

  // Fill target and lookup result.
  always_comb begin
    fill_tgt   = fl_hit ? fl_way : vic_way;
    fill_do    = fill_valid_i && (fl_hit || vic_found);
    lk_hit_act = lk_valid_i && lk_hit;
    hit_rank   = lk_rank[lk_way*POS_W +: POS_W];
    pos_d      = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (val_q[lk_set][w] && way_en_i[w] && (lk_rank[w*POS_W +: POS_W] < hit_rank))
        pos_d = pos_d + POS_W'(1);
    end
    if (!lk_hit) pos_d = '0;
    ppn_d = lk_hit ? ppn_q[lk_set][lk_way] : '0;
  end

  // Per-set recency control: a fill in the set overrides a lookup hit there.
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      touch_src[s] = TOUCH_NONE;
      touch_way[s] = lk_way;
      if (fill_do && (fl_set == IDX_W'(s))) begin
        touch_src[s] = TOUCH_FILL;
        touch_way[s] = fill_tgt;
      end else if (lk_hit_act && (lk_set == IDX_W'(s))) begin
        touch_src[s] = TOUCH_HIT;
      end
      touch[s] = (touch_src[s] != TOUCH_NONE);
    end
  end

  for (genvar s = 0; s < SETS; s++) begin : g_set
    tlb_lru_stack #(.WAYS(WAYS)) u_lru (
      .clk(clk), .rst_n(rst_n), .touch_i(touch[s]),
      .touch_way_i(touch_way[s]), .rank_o(rank_all[s])
    );
  end

  // Valid bits: gated by the mask every cycle, set by a fill.
  always_comb begin
    for (int s = 0; s < SETS; s++) begin
      val_d[s] = val_q[s] & way_en_i;
      if (fill_do && (fl_set == IDX_W'(s))) val_d[s][fill_tgt] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) val_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) val_q[s] <= val_d[s];
    end
  end

  // Tag and PPN storage: written only by a fill, no reset.
  always_ff @(posedge clk) begin
    if (fill_do) begin
      tag_q[fl_set][fill_tgt] <= fill_vpn_i;
      ppn_q[fl_set][fill_tgt] <= fill_ppn_i;
    end
  end

  // Registered response.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_ppn_o   <= '0;
      rsp_pos_o   <= '0;
    end else begin
      rsp_valid_o <= lk_valid_i;
      if (lk_valid_i) begin
        rsp_hit_o <= lk_hit;
        rsp_ppn_o <= ppn_d;
        rsp_pos_o <= pos_d;
      end
    end
  end

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      way_live[w] = 1'b0;
      for (int s = 0; s < SETS; s++) way_live[w] = way_live[w] | val_q[s][w];
    end
  end

  // R8
  for (genvar w = 0; w < WAYS; w++) begin : g_gate_chk
    way_off_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !way_en_i[w] |=> !way_live[w]);
  end

  // R7
  lk_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(lk_hit_vec));

  // R7
  fl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(fl_hit_vec));

  // R2
  rsp_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid_i |=> rsp_valid_o);

  // R3
  miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_ppn_o == '0 && rsp_pos_o == '0));

  // R9
  no_way_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid_i && way_en_i == '0) |=> !rsp_hit_o);
endmodule

// File: tb/tb_way_gated_tlb.sv
module tb_way_gated_tlb;
  localparam int WAYS = 8, SETS = 16, VPN_W = 20, PPN_W = 20, POS_W = 3;
  localparam int FA_WAYS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic             lk_valid = 0, fill_valid = 0;
  logic [VPN_W-1:0] lk_vpn = '0, fill_vpn = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic [WAYS-1:0]  way_en = '1;
  logic             rsp_valid, rsp_hit;
  logic [PPN_W-1:0] rsp_ppn;
  logic [POS_W-1:0] rsp_pos;

  way_gated_tlb #(.WAYS(WAYS), .SETS(SETS), .VPN_W(VPN_W), .PPN_W(PPN_W)) dut (
    .clk(clk), .rst_n(rst_n), .lk_valid_i(lk_valid), .lk_vpn_i(lk_vpn),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_ppn_i(fill_ppn),
    .way_en_i(way_en), .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit),
    .rsp_ppn_o(rsp_ppn), .rsp_pos_o(rsp_pos)
  );

  logic             fa_lk = 0, fa_fl = 0;
  logic [VPN_W-1:0] fa_lvpn = '0, fa_fvpn = '0;
  logic [PPN_W-1:0] fa_fppn = '0;
  logic             fa_rv, fa_rh;
  logic [PPN_W-1:0] fa_rppn;
  logic [1:0]       fa_rpos;

  way_gated_tlb #(.WAYS(FA_WAYS), .SETS(1), .VPN_W(VPN_W), .PPN_W(PPN_W)) dut_fa (
    .clk(clk), .rst_n(rst_n), .lk_valid_i(fa_lk), .lk_vpn_i(fa_lvpn),
    .fill_valid_i(fa_fl), .fill_vpn_i(fa_fvpn), .fill_ppn_i(fa_fppn),
    .way_en_i(4'hF), .rsp_valid_o(fa_rv), .rsp_hit_o(fa_rh),
    .rsp_ppn_o(fa_rppn), .rsp_pos_o(fa_rpos)
  );

  int checks = 0, failures = 0;
  string cur_req = "R2";

  // Behavioural model: per set, contents plus a recency queue (front = newest).
  int m_vpn [SETS][WAYS];
  int m_ppn [SETS][WAYS];
  bit m_val [SETS][WAYS];
  int ord   [SETS][$];
  bit exp_v, exp_hit;
  int exp_ppn, exp_pos;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic void to_front(int s, int w);
    for (int i = 0; i < ord[s].size(); i++) begin
      if (ord[s][i] == w) begin ord[s].delete(i); break; end
    end
    ord[s].push_front(w);
  endfunction

  function automatic void model_step(bit lk, int lv, bit fl, int fv, int fp, bit [WAYS-1:0] en);
    int ls, fs, hw, tgt;
    bit hit;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) if (!en[w]) m_val[s][w] = 0;
    ls = lv % SETS; fs = fv % SETS; hit = 0; hw = 0;
    exp_v = lk; exp_hit = 0; exp_ppn = 0; exp_pos = 0;
    if (lk) begin
      for (int w = 0; w < WAYS; w++) if (m_val[ls][w] && m_vpn[ls][w] == lv) begin hit = 1; hw = w; end
      if (hit) begin
        exp_hit = 1; exp_ppn = m_ppn[ls][hw];
        foreach (ord[ls][i]) begin
          if (ord[ls][i] == hw) break;
          if (m_val[ls][ord[ls][i]]) exp_pos++;
        end
      end
    end
    if (fl && en != '0) begin
      tgt = -1;
      for (int w = 0; w < WAYS; w++) if (m_val[fs][w] && m_vpn[fs][w] == fv) tgt = w;
      if (tgt < 0) for (int w = WAYS - 1; w >= 0; w--) if (en[w] && !m_val[fs][w]) tgt = w;
      if (tgt < 0) foreach (ord[fs][i]) if (en[ord[fs][i]]) tgt = ord[fs][i];
      m_vpn[fs][tgt] = fv; m_ppn[fs][tgt] = fp; m_val[fs][tgt] = 1;
      to_front(fs, tgt);
    end
    if (hit && !(fl && fs == ls && en != '0)) to_front(ls, hw);
  endfunction

  // One clock: judge the previous response, then drive and predict the next.
  task automatic cyc(bit lk, int lv, bit fl, int fv, int fp, bit [WAYS-1:0] en);
    @(negedge clk);
    check(rsp_valid == exp_v, cur_req, "rsp_valid", rsp_valid, exp_v);
    if (exp_v && rsp_valid) begin
      check(rsp_hit == exp_hit, cur_req, "hit", rsp_hit, exp_hit);
      check(rsp_ppn == PPN_W'(exp_ppn), cur_req, "ppn", rsp_ppn, exp_ppn);
      check(rsp_pos == POS_W'(exp_pos), exp_hit ? "R4" : "R3", "pos", rsp_pos, exp_pos);
    end
    lk_valid = lk; lk_vpn = VPN_W'(lv); fill_valid = fl; fill_vpn = VPN_W'(fv);
    fill_ppn = PPN_W'(fp); way_en = en;
    model_step(lk, lv, fl, fv, fp, en);
  endtask

  task automatic fa_cyc(bit lk, int lv, bit fl, int fv, int fp);
    @(negedge clk);
    fa_lk = lk; fa_lvpn = VPN_W'(lv); fa_fl = fl; fa_fvpn = VPN_W'(fv); fa_fppn = PPN_W'(fp);
  endtask

  task automatic fa_expect(bit hit, int ppn, int pos);
    @(negedge clk);
    check(fa_rv && fa_rh == hit, "R11", "fa hit", fa_rh, hit);
    check(fa_rppn == PPN_W'(ppn) && fa_rpos == 2'(pos), "R11", "fa ppn/pos", int'(fa_rppn) * 10 + int'(fa_rpos), ppn * 10 + pos);
    fa_lk = 0; fa_fl = 0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    bit [WAYS-1:0] mask;
    int lv, fv;
    for (int s = 0; s < SETS; s++)
      for (int w = 0; w < WAYS; w++) begin ord[s].push_back(w); m_val[s][w] = 0; end
    exp_v = 0;
    repeat (3) @(negedge clk);
    check(rsp_valid == 0, "R1", "rsp_valid in reset", rsp_valid, 0);
    rst_n = 1'b1;

    // R1: cold lookups miss
    cur_req = "R1";
    for (int i = 0; i < 20; i++) cyc(1, i * 37, 0, 0, 0, '1);

    // R4 R5: three entries in one set, reorder by hits
    cur_req = "R4,R5";
    cyc(0, 0, 1, 16'h0103, 11, '1);
    cyc(0, 0, 1, 16'h0203, 22, '1);
    cyc(0, 0, 1, 16'h0303, 33, '1);
    cyc(1, 16'h0103, 0, 0, 0, '1);
    cyc(1, 16'h0103, 0, 0, 0, '1);
    cyc(1, 16'h0203, 0, 0, 0, '1);
    cyc(1, 16'h0303, 0, 0, 0, '1);

    // R7: refill of a present VPN rewrites in place
    cur_req = "R7";
    cyc(0, 0, 1, 16'h0203, 77, '1);
    cyc(1, 16'h0203, 0, 0, 0, '1);
    cyc(1, 16'h0103, 0, 0, 0, '1);

    // R2 R6: random traffic with evictions, all ways on
    cur_req = "R2,R6";
    for (int i = 0; i < 3000; i++) begin
      lv = int'($urandom_range(0, 255)); fv = int'($urandom_range(0, 255));
      cyc($urandom_range(0, 9) < 7, lv, $urandom_range(0, 9) < 4, fv, int'($urandom_range(1, 50000)), '1);
    end

    // R8: changing masks
    cur_req = "R8";
    mask = '1;
    for (int i = 0; i < 3000; i++) begin
      if (i % 17 == 0) mask = WAYS'($urandom);
      lv = int'($urandom_range(0, 255)); fv = int'($urandom_range(0, 255));
      cyc($urandom_range(0, 9) < 7, lv, $urandom_range(0, 9) < 4, fv, int'($urandom_range(1, 50000)), mask);
    end

    // R9: no ways enabled
    cur_req = "R9";
    for (int i = 0; i < 60; i++)
      cyc(1, int'($urandom_range(0, 255)), 1, int'($urandom_range(0, 255)), 5, '0);
    for (int i = 0; i < 20; i++) cyc(1, int'($urandom_range(0, 255)), 0, 0, 0, '1);

    // R10: same-set lookup and fill in one cycle
    cur_req = "R10";
    mask = '1;
    for (int i = 0; i < 2000; i++) begin
      if (i % 29 == 0) mask = WAYS'($urandom) | WAYS'(1);
      lv = int'($urandom_range(0, 127));
      fv = ($urandom_range(0, 3) == 0) ? lv : ((int'($urandom_range(0, 7)) << 4) | (lv % SETS));
      cyc(1, lv, $urandom_range(0, 9) < 6, fv, int'($urandom_range(1, 50000)), mask);
    end
    cyc(0, 0, 0, 0, 0, '1);
    cyc(0, 0, 0, 0, 0, '1);

    // R11: fully associative instance, four entries, LRU eviction
    fa_cyc(0, 0, 1, 100, 1); fa_cyc(0, 0, 1, 101, 2);
    fa_cyc(0, 0, 1, 102, 3); fa_cyc(0, 0, 1, 103, 4);
    fa_cyc(1, 100, 0, 0, 0); fa_expect(1, 1, 3);
    fa_cyc(0, 0, 1, 104, 5);
    fa_cyc(1, 101, 0, 0, 0); fa_expect(0, 0, 0);
    fa_cyc(1, 104, 0, 0, 0); fa_expect(1, 5, 0);
    fa_cyc(1, 102, 0, 0, 0); fa_expect(1, 3, 3);

    summary();
    $finish;
  end
endmodule